// File: doc/BRIEF.md
# Full-Frame CCD Clock Sequencer

This block produces the logic-level clock enables for a full-frame CCD with one horizontal output. The enables are the two vertical phases, the two horizontal phases and the reset gate. A pulse on `frame_start` begins a frame. The frame opens with an integration period, during which the vertical clocks rest low. Each line then follows the same pattern:

- a vertical transfer made of a phase-1 pulse and then a phase-2 pulse;
- a horizontal setup gap;
- a fixed number of horizontal pixel counts.

The last line of the frame is followed by a one-cycle completion strobe.

Four timing values are given in system-clock cycles: integration length, vertical pulse width, horizontal setup length and half of the pixel period. They are captured when a frame is accepted and held for the whole frame. `PIX_PER_LINE` sets the horizontal count per line and `LINES_PER_FRAME` sets the line count. Both are fixed at elaboration, and the pixel count can be larger than the active width of the array.

Downstream sampling logic uses three strobes: pixel-valid, line-start and frame-done. The reset-gate pulse runs at all times, including while the block is idle.

Top module: `ccd_clock_seq`

## Requirements
- R1: After reset, the outputs are `busy`=0, `v1`=0, `v2`=0, `h1`=1 and `h2`=0, and all three strobes are 0.
- R2: A `frame_start` seen while idle raises `busy` on the next cycle. An integration period of `cfg_integ` cycles follows, with `v1` and `v2` both low.
- R3: Each line begins with `v1` high for `cfg_vwidth` cycles. `v2` is high for the next `cfg_vwidth` cycles, and the two are never high together.
- R4: `v2` falls while `h1`=1 and `h2`=0. A setup gap of `cfg_hsetup` cycles, with `h1`=1 and `h2`=0, comes before the first horizontal change.
- R5: The shift phase lasts `PIX_PER_LINE` pixels, and each pixel takes 2·`cfg_half_pix` cycles. `h2`=1 and `h1`=0 in the first half of each pixel and `h1`=1 and `h2`=0 in the second half. `pix_valid` is a one-cycle pulse on the last cycle of each pixel.
- R6: `line_start` is a one-cycle pulse on the first shift cycle of each line. A frame holds `LINES_PER_FRAME` lines, and each line takes 2·vwidth + hsetup + `PIX_PER_LINE`·2·half cycles.
- R7: `frame_done` pulses for one cycle right after the last pixel of the last line, and `busy` falls on the next cycle.
- R8: `rg` is a one-cycle pulse every 2·half cycles at all times, including idle. In the shift phase it falls on the first cycle of every pixel.
- R9: The timing inputs are captured only when a frame is accepted. Changes to them during a frame have no effect on that frame or on the idle `rg` period after it.
- R10: A `frame_start` that arrives while `busy`=1 is dropped. The frame keeps its timing, and no new frame begins after it ends.
- R11: A timing value of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame request pulse |
| cfg_integ | input | 24 | Integration length in cycles |
| cfg_vwidth | input | 24 | Width of each vertical phase pulse in cycles |
| cfg_hsetup | input | 24 | Horizontal setup gap in cycles |
| cfg_half_pix | input | 8 | Half the pixel period in cycles |
| busy | output | 1 | A frame is in progress |
| v1 | output | 1 | Vertical phase-1 enable |
| v2 | output | 1 | Vertical phase-2 enable |
| h1 | output | 1 | Horizontal phase-1 enable |
| h2 | output | 1 | Horizontal phase-2 enable |
| rg | output | 1 | Reset-gate pulse |
| pix_valid | output | 1 | Pixel sample strobe |
| line_start | output | 1 | First shift cycle of a line |
| frame_done | output | 1 | End-of-frame strobe |

## Verification
The hardest case to reach from the ports is a second request that lands in the middle of a frame and carries different timing values. If it leaked through, it could restart the sequence or change the timing of later lines. The stimulus raises `frame_start` and changes every timing input a few cycles after integration ends. It then checks that all later line, pixel and frame events still land on the cycles predicted from the first values. It also checks that no frame begins after `busy` falls, and that the idle `rg` period still follows the captured half-period. A frame with every timing input at zero covers the minimum case, where each phase is one cycle long.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    localparam int SEQ_CNT_W  = 24;
    localparam int SEQ_HALF_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INTEG,
        S_VPH1,
        S_VPH2,
        S_HSET,
        S_HSHIFT,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic [SEQ_CNT_W-1:0]  t_int;
        logic [SEQ_CNT_W-1:0]  t_vw;
        logic [SEQ_CNT_W-1:0]  t_hs;
        logic [SEQ_HALF_W-1:0] t_half;
    } seq_cfg_t;

    localparam seq_cfg_t SEQ_CFG_MIN = '{
        t_int:  SEQ_CNT_W'(1),
        t_vw:   SEQ_CNT_W'(1),
        t_hs:   SEQ_CNT_W'(1),
        t_half: SEQ_HALF_W'(1)
    };

    // zero durations become one cycle
    function automatic seq_cfg_t clamp_cfg(seq_cfg_t c);
        seq_cfg_t r;
        r.t_int  = (c.t_int  == '0) ? SEQ_CNT_W'(1)  : c.t_int;
        r.t_vw   = (c.t_vw   == '0) ? SEQ_CNT_W'(1)  : c.t_vw;
        r.t_hs   = (c.t_hs   == '0) ? SEQ_CNT_W'(1)  : c.t_hs;
        r.t_half = (c.t_half == '0) ? SEQ_HALF_W'(1) : c.t_half;
        return r;
    endfunction

endpackage

// File: rtl/ccdseq_cfg_latch.sv
module ccdseq_cfg_latch
    import ccdseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  seq_cfg_t cfg_in,
    output seq_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= SEQ_CFG_MIN;
        end else if (load) begin
            cfg_q <= clamp_cfg(cfg_in);
        end
    end

endmodule

// File: rtl/ccdseq_pixel_timer.sv
module ccdseq_pixel_timer
    import ccdseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SEQ_HALF_W-1:0] half,
    input  logic                  restart,
    input  logic                  shifting,
    output logic                  rg,
    output logic                  h1,
    output logic                  h2,
    output logic                  pix_end
);

    localparam int PH_W = SEQ_HALF_W + 1;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] last_ph;

    assign last_ph = {half, 1'b0} - PH_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (restart || phase >= last_ph) begin
            phase <= '0;
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

    assign rg      = (phase == '0);
    assign pix_end = shifting && (phase == last_ph);
    assign h2      = shifting && (phase < {1'b0, half});
    assign h1      = !h2;

    // R8
    rg_on_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> rg);

endmodule

// File: rtl/ccdseq_fsm.sv
module ccdseq_fsm
    import ccdseq_pkg::*;
#(
    parameter int PIX_PER_LINE    = 4145,
    parameter int LINES_PER_FRAME = 4128
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_start,
    input  seq_cfg_t cfg,
    input  logic     pix_end,
    output logic     load,
    output logic     restart,
    output logic     shifting,
    output logic     busy,
    output logic     v1,
    output logic     v2,
    output logic     line_start,
    output logic     frame_done
);

    localparam int PIX_W  = (PIX_PER_LINE > 1) ? $clog2(PIX_PER_LINE) : 1;
    localparam int LINE_W = (LINES_PER_FRAME > 1) ? $clog2(LINES_PER_FRAME) : 1;

    seq_state_t st, st_n;
    logic [SEQ_CNT_W-1:0] cnt;
    logic [PIX_W-1:0]     pix;
    logic [LINE_W-1:0]    line;
    logic                 dur_end;
    logic                 line_end;

    always_comb begin
        unique case (st)
            S_INTEG:         dur_end = (cnt == cfg.t_int - SEQ_CNT_W'(1));
            S_VPH1, S_VPH2:  dur_end = (cnt == cfg.t_vw - SEQ_CNT_W'(1));
            S_HSET:          dur_end = (cnt == cfg.t_hs - SEQ_CNT_W'(1));
            default:         dur_end = 1'b0;
        endcase
    end

    assign load     = (st == S_IDLE) && frame_start;
    assign restart  = (st == S_HSET) && dur_end;
    assign line_end = (st == S_HSHIFT) && pix_end && (pix == PIX_W'(PIX_PER_LINE - 1));

    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:   if (frame_start) st_n = S_INTEG;
            S_INTEG:  if (dur_end)     st_n = S_VPH1;
            S_VPH1:   if (dur_end)     st_n = S_VPH2;
            S_VPH2:   if (dur_end)     st_n = S_HSET;
            S_HSET:   if (dur_end)     st_n = S_HSHIFT;
            S_HSHIFT: if (line_end)
                          st_n = (line == LINE_W'(LINES_PER_FRAME - 1)) ? S_DONE : S_VPH1;
            S_DONE:   st_n = S_IDLE;
            default:  st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            cnt  <= '0;
            pix  <= '0;
            line <= '0;
        end else begin
            st  <= st_n;
            cnt <= (st_n != st) ? '0 : cnt + SEQ_CNT_W'(1);
            if (st != S_HSHIFT)  pix <= '0;
            else if (pix_end)    pix <= pix + PIX_W'(1);
            if (st == S_IDLE)    line <= '0;
            else if (line_end)   line <= line + LINE_W'(1);
        end
    end

    assign shifting   = (st == S_HSHIFT);
    assign busy       = (st != S_IDLE);
    assign v1         = (st == S_VPH1);
    assign v2         = (st == S_VPH2);
    assign frame_done = (st == S_DONE);
    assign line_start = (st == S_HSHIFT) && (cnt == '0) && (pix == '0);

    // R2
    integ_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> busy && !v1 && !v2);
    // R3
    v2_after_v1_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(v1) |-> v2);
    // R7
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !busy);
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !frame_done && frame_start |=> busy);

endmodule

// File: rtl/ccd_clock_seq.sv
module ccd_clock_seq
    import ccdseq_pkg::*;
#(
    parameter int PIX_PER_LINE    = 4145,
    parameter int LINES_PER_FRAME = 4128
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_start,
    input  logic [SEQ_CNT_W-1:0]  cfg_integ,
    input  logic [SEQ_CNT_W-1:0]  cfg_vwidth,
    input  logic [SEQ_CNT_W-1:0]  cfg_hsetup,
    input  logic [SEQ_HALF_W-1:0] cfg_half_pix,
    output logic                  busy,
    output logic                  v1,
    output logic                  v2,
    output logic                  h1,
    output logic                  h2,
    output logic                  rg,
    output logic                  pix_valid,
    output logic                  line_start,
    output logic                  frame_done
);

    seq_cfg_t cfg_in, cfg_q;
    logic     load, restart, shifting, pix_end;

    assign cfg_in = '{t_int: cfg_integ, t_vw: cfg_vwidth,
                      t_hs: cfg_hsetup, t_half: cfg_half_pix};

    ccdseq_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    ccdseq_fsm #(
        .PIX_PER_LINE    (PIX_PER_LINE),
        .LINES_PER_FRAME (LINES_PER_FRAME)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .cfg         (cfg_q),
        .pix_end     (pix_end),
        .load        (load),
        .restart     (restart),
        .shifting    (shifting),
        .busy        (busy),
        .v1          (v1),
        .v2          (v2),
        .line_start  (line_start),
        .frame_done  (frame_done)
    );

    ccdseq_pixel_timer u_pix (
        .clk      (clk),
        .rst      (rst),
        .half     (cfg_q.t_half),
        .restart  (restart),
        .shifting (shifting),
        .rg       (rg),
        .h1       (h1),
        .h2       (h2),
        .pix_end  (pix_end)
    );

    assign pix_valid = pix_end;

    // R4
    v2_fall_h1_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(v2) |-> h1 && !h2);
    // R8
    line_start_rg_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |-> rg);
    // R5
    pix_valid_h1_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> h1 && !h2);

endmodule

// File: tb/ccd_clock_seq_bench.sv
module ccd_clock_seq_bench;
    import ccdseq_pkg::*;

    localparam int PIX   = 6;
    localparam int LINES = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic [SEQ_CNT_W-1:0]  ti = '0, tv = '0, ts = '0;
    logic [SEQ_HALF_W-1:0] th = '0;
    logic busy, v1, v2, h1, h2, rg, pix_valid, line_start, frame_done;

    always #2 clk = ~clk;

    ccd_clock_seq #(.PIX_PER_LINE(PIX), .LINES_PER_FRAME(LINES)) u_ccd_clock_seq (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .cfg_integ(ti), .cfg_vwidth(tv), .cfg_hsetup(ts), .cfg_half_pix(th),
        .busy(busy), .v1(v1), .v2(v2), .h1(h1), .h2(h2), .rg(rg),
        .pix_valid(pix_valid), .line_start(line_start), .frame_done(frame_done)
    );

    int checks = 0;
    int errors = 0;

    typedef struct { int kind; int cyc; } ev_t;   // kind 0 line_start, 1 pix_valid, 2 frame_done
    ev_t q[$];

    int e_int = 1, e_vw = 1, e_hs = 1, e_h = 1;
    int cyc = 0;
    bit prev_busy = 1'b0;
    int vert_err = 0, horiz_err = 0, rg_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cl(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic pop_ev(input int k);
        ev_t e;
        string req;
        req = (k == 0) ? "R6" : (k == 1) ? "R5" : "R7";
        if (q.size() == 0) begin
            chk(1'b0, req, "unexpected event kind", k, -1);
        end else begin
            e = q.pop_front();
            chk(e.kind == k, req, "event kind", k, e.kind);
            chk(e.cyc == cyc, req, "event cycle", cyc, e.cyc);
        end
    endtask

    // monitor: compares the waveform and pops scoreboard events
    always @(negedge clk) begin
        if (!rst) begin
            if (busy && !prev_busy) cyc = 0;
            else cyc++;
            prev_busy = busy;
            if (busy) begin
                int line_len, r, m, qq;
                bit xv1, xv2, xh1, xh2;
                line_len = 2 * e_vw + e_hs + PIX * 2 * e_h;
                xv1 = 0; xv2 = 0; xh1 = 1; xh2 = 0;
                if (cyc >= e_int && cyc - e_int < LINES * line_len) begin
                    r = cyc - e_int;
                    m = r % line_len;
                    xv1 = (m < e_vw);
                    xv2 = (m >= e_vw) && (m < 2 * e_vw);
                    if (m >= 2 * e_vw + e_hs) begin
                        qq = (m - 2 * e_vw - e_hs) % (2 * e_h);
                        xh2 = (qq < e_h);
                        xh1 = !xh2;
                        if (rg != (qq == 0)) rg_err++;
                    end
                end
                if (v1 != xv1 || v2 != xv2) vert_err++;
                if (h1 != xh1 || h2 != xh2) horiz_err++;
                if (line_start) pop_ev(0);
                if (pix_valid)  pop_ev(1);
                if (frame_done) pop_ev(2);
            end else if (line_start || pix_valid || frame_done) begin
                chk(1'b0, "R7", "strobe while idle", 1, 0);
            end
        end
    end

    // driver: pushes expected events, then runs the frame
    task automatic run_frame(input int a, input int b, input int c, input int d,
                             input bit disturb, input string tag);
        int line_len, len, s, cnt;
        e_int = cl(a); e_vw = cl(b); e_hs = cl(c); e_h = cl(d);
        line_len = 2 * e_vw + e_hs + PIX * 2 * e_h;
        for (int l = 0; l < LINES; l++) begin
            s = e_int + 2 * e_vw + e_hs + l * line_len;
            q.push_back('{0, s});
            for (int p = 0; p < PIX; p++) q.push_back('{1, s + p * 2 * e_h + 2 * e_h - 1});
        end
        q.push_back('{2, e_int + LINES * line_len});
        vert_err = 0; horiz_err = 0; rg_err = 0;
        @(negedge clk);
        ti = SEQ_CNT_W'(a); tv = SEQ_CNT_W'(b); ts = SEQ_CNT_W'(c); th = SEQ_HALF_W'(d);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        // R2
        chk(busy == 1'b1, "R2", "busy after accepted start", busy, 1);
        len = 0;
        while (busy) begin
            len++;
            if (disturb && len == e_int + 3) begin
                ti = 24'd7; tv = 24'd2; ts = 24'd9; th = 8'd3;
                frame_start = 1'b1;   // R10, R9: must be dropped
            end else begin
                frame_start = 1'b0;
            end
            @(negedge clk);
        end
        frame_start = 1'b0;
        chk(len == e_int + LINES * line_len + 1, tag, "busy length", len,
            e_int + LINES * line_len + 1);
        chk(q.size() == 0, "R6", "missing events", q.size(), 0);
        chk(vert_err == 0, "R3", "vertical waveform mismatches", vert_err, 0);
        chk(horiz_err == 0, "R4", "horizontal waveform mismatches", horiz_err, 0);
        chk(rg_err == 0, "R8", "rg in shift phase mismatches", rg_err, 0);
        q.delete();
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10", "no frame after completion", busy, 0);
        // R8 idle rg period follows captured half-period (R9 when disturbed)
        cnt = 0;
        for (int i = 0; i < 8 * e_h; i++) begin
            @(negedge clk);
            if (rg) cnt++;
        end
        chk(cnt == 4, disturb ? "R9" : "R8", "idle rg pulses", cnt, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(busy == 0 && v1 == 0 && v2 == 0, "R1", "reset vertical/busy",
            {busy, v1, v2}, 0);
        chk(h1 == 1 && h2 == 0, "R1", "reset horizontal", {h1, h2}, 2);
        chk(!pix_valid && !line_start && !frame_done, "R1", "reset strobes",
            {pix_valid, line_start, frame_done}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        run_frame(5, 3, 4, 2, 1'b0, "R6");
        run_frame(2, 1, 1, 1, 1'b1, "R10");
        run_frame(0, 0, 0, 0, 1'b0, "R11");
        run_frame(9, 2, 6, 3, 1'b1, "R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule